// File: doc/BRIEF.md
# Paged Register Bridge over Management Reads and Writes

This block lets a host read or write a register of 1 to 8 bytes that lives in a paged register space behind a 16-bit management interface. Each host request names a page, a register and a length. The block turns it into a series of single 16-bit management accesses, all aimed at one fixed PHY address. It writes a page select register when the page differs from the one it last programmed. It moves the value through four 16-bit data windows and writes a command register with the target register and an opcode. It then polls that command register until its opcode field clears, or until a poll limit is reached.

The host request channel uses valid/ready. A request is taken in the cycle where `req_valid` and `req_ready` are both high. Request fields only need to be valid in that cycle. `req_ready` is high only while the block is idle, so one request is in flight at a time, and a host that holds `req_valid` simply waits. Completion is reported by a one-cycle `done` pulse, with `err` and `rdata` valid in the same cycle. The management side raises `mg_req` with stable fields until the far side answers with a one-cycle `mg_ack`, which also carries `mg_rdata` for reads. The serial framing behind that port is handled elsewhere.

Top module: `mdio_page_bridge`

## Requirements
- R1: Every management access uses PHY address 0x1E.
- R2: On a page change the block writes register 0x10 with the page in bits [15:8], bits [7:1] zero and bit 0 set. This write is skipped when the page equals the last programmed page. No page counts as programmed after reset.
- R3: The command register 0x11 is written with the target register in bits [15:8], bits [7:2] zero and the opcode in bits [1:0]: 1 for write, 2 for read.
- R4: For a write, data windows 0x18..0x1B are written before the command, highest window first. Byte k of the value goes to window 0x18+k/2, in the low byte when k is even. Length 8 uses 0x1B..0x18, length 6 uses 0x1A..0x18, length 4 uses 0x19 and 0x18, and lengths 1 and 2 use 0x18 only. Write-data bytes at or above the length are sent as zero.
- R5: After the command, register 0x11 is read until bits [1:0] read zero. If 100 polls all read busy, the request ends with `err` high and no data window is read.
- R6: For a read, the windows are read only after completion, highest window first, and assembled with byte 0 in the low byte of 0x18. `rdata` bytes at or above the length are zero, so a 1-byte read returns only the low byte of 0x18.
- R7: A length other than 1, 2, 4, 6 or 8 ends the request with `err` high and no management access.
- R8: At most one management access is pending. `mg_req`, `mg_write`, `mg_regnum` and `mg_wdata` stay stable from the rise of `mg_req` until `mg_ack`. `mg_req` is low whenever the block is idle.
- R9: `req_ready` is high only when idle and goes low in the cycle after a request is accepted. `done` is high for exactly one cycle per request, and `err` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_page | input | 8 | Target page |
| req_reg | input | 8 | Target register within the page |
| req_len | input | 4 | Access length in bytes |
| req_wdata | input | 64 | Write value, byte 0 in bits [7:0] |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request failed (bad length or poll timeout), valid with done |
| rdata | output | 64 | Read value, valid with done |
| mg_req | output | 1 | Management access request |
| mg_write | output | 1 | 1 = management write, 0 = read |
| mg_phy | output | 5 | Management PHY address |
| mg_regnum | output | 5 | Management register number |
| mg_wdata | output | 16 | Management write data |
| mg_ack | input | 1 | Management access finished (one cycle) |
| mg_rdata | input | 16 | Management read data, valid with mg_ack |

## Verification
The hardest situation to reach is the poll limit. The timeout path only runs when the far side reports busy on every one of 100 consecutive polls, and the case one poll short of the limit must still succeed. The bench's management responder keeps an adjustable busy count that is armed by each command write. Directed requests set this count to 99 and to 150, and the bench checks that exactly 100 polls are logged in both cases. Only the second ends with an error.

// File: rtl/mpb_pkg.sv
package mpb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAGE,
    ST_WDATA,
    ST_CMD,
    ST_POLL,
    ST_RDATA,
    ST_FINISH
  } mpb_state_e;

  localparam int MG_REG_W = 5;
  localparam logic [MG_REG_W-1:0] REG_PAGE_SEL = 5'h10;
  localparam logic [MG_REG_W-1:0] REG_COMMAND  = 5'h11;
  localparam logic [MG_REG_W-1:0] REG_WINDOW0  = 5'h18;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
endpackage

// File: rtl/mpb_len_decode.sv
module mpb_len_decode #(
  parameter int LEN_W  = 4,
  parameter int DATA_W = 64,
  parameter int WIN_W  = 2
) (
  input  logic [LEN_W-1:0]  len,
  output logic              len_ok,
  output logic [WIN_W-1:0]  top_win,
  output logic [DATA_W-1:0] byte_mask
);
  localparam int NBYTES = DATA_W / 8;

  assign len_ok  = (len != '0) && (len <= LEN_W'(NBYTES)) && ((len == LEN_W'(1)) || !len[0]);
  assign top_win = WIN_W'((len - LEN_W'(1)) >> 1);

  for (genvar b = 0; b < NBYTES; b++) begin : g_mask
    assign byte_mask[8*b +: 8] = (LEN_W'(b) < len) ? 8'hFF : 8'h00;
  end
endmodule

// File: rtl/mpb_page_cache.sv
module mpb_page_cache #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PAGE_W-1:0] load_page,
  input  logic [PAGE_W-1:0] cmp_page,
  output logic              hit
);
  logic              valid_q;
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      page_q  <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      page_q  <= load_page;
    end
  end

  assign hit = valid_q && (page_q == cmp_page);
endmodule

// File: rtl/mpb_poll_ctr.sv
module mpb_poll_ctr #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output logic last
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else if (inc)        cnt_q <= cnt_q + CW'(1);
  end

  assign last = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/mdio_page_bridge.sv
module mdio_page_bridge
  import mpb_pkg::*;
#(
  parameter int              PAGE_W     = 8,
  parameter int              REG_W      = 8,
  parameter int              LEN_W      = 4,
  parameter int              DATA_W     = 64,
  parameter int              MG_DATA_W  = 16,
  parameter int              PHY_W      = 5,
  parameter logic [PHY_W-1:0] PHY_ADDR  = 5'h1E,
  parameter int              POLL_LIMIT = 100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [PAGE_W-1:0]    req_page,
  input  logic [REG_W-1:0]     req_reg,
  input  logic [LEN_W-1:0]     req_len,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 done,
  output logic                 err,
  output logic [DATA_W-1:0]    rdata,
  output logic                 mg_req,
  output logic                 mg_write,
  output logic [PHY_W-1:0]     mg_phy,
  output logic [MG_REG_W-1:0]  mg_regnum,
  output logic [MG_DATA_W-1:0] mg_wdata,
  input  logic                 mg_ack,
  input  logic [MG_DATA_W-1:0] mg_rdata
);
  localparam int NWIN  = DATA_W / MG_DATA_W;
  localparam int WIN_W = (NWIN > 1) ? $clog2(NWIN) : 1;

  mpb_state_e         state_q;
  logic               is_wr_q, err_q;
  logic [PAGE_W-1:0]  page_q;
  logic [REG_W-1:0]   reg_q;
  logic [DATA_W-1:0]  wbuf_q, rbuf_q, mask_q;
  logic [WIN_W-1:0]   win_q, top_q;

  logic               len_ok, page_hit, poll_last, accept, op_done;
  logic [WIN_W-1:0]   len_top;
  logic [DATA_W-1:0]  len_mask;

  mpb_len_decode #(.LEN_W(LEN_W), .DATA_W(DATA_W), .WIN_W(WIN_W)) u_len (
    .len(req_len), .len_ok(len_ok), .top_win(len_top), .byte_mask(len_mask)
  );

  mpb_page_cache #(.PAGE_W(PAGE_W)) u_page (
    .clk(clk), .rst_n(rst_n),
    .load(state_q == ST_PAGE && mg_ack), .load_page(page_q),
    .cmp_page(req_page), .hit(page_hit)
  );

  mpb_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_n),
    .clear(state_q == ST_CMD), .inc(state_q == ST_POLL && mg_ack),
    .last(poll_last)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign op_done   = (mg_rdata[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      is_wr_q <= 1'b0;
      err_q   <= 1'b0;
      page_q  <= '0;
      reg_q   <= '0;
      wbuf_q  <= '0;
      rbuf_q  <= '0;
      mask_q  <= '0;
      win_q   <= '0;
      top_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          is_wr_q <= req_write;
          page_q  <= req_page;
          reg_q   <= req_reg;
          wbuf_q  <= req_wdata & len_mask;
          mask_q  <= len_mask;
          rbuf_q  <= '0;
          win_q   <= len_top;
          top_q   <= len_top;
          err_q   <= !len_ok;
          if (!len_ok)       state_q <= ST_FINISH;
          else if (!page_hit) state_q <= ST_PAGE;
          else if (req_write) state_q <= ST_WDATA;
          else                state_q <= ST_CMD;
        end
        ST_PAGE: if (mg_ack) state_q <= is_wr_q ? ST_WDATA : ST_CMD;
        ST_WDATA: if (mg_ack) begin
          if (win_q == '0) state_q <= ST_CMD;
          else             win_q   <= win_q - WIN_W'(1);
        end
        ST_CMD: if (mg_ack) state_q <= ST_POLL;
        ST_POLL: if (mg_ack) begin
          if (op_done) begin
            if (is_wr_q) state_q <= ST_FINISH;
            else begin
              win_q   <= top_q;
              state_q <= ST_RDATA;
            end
          end else if (poll_last) begin
            err_q   <= 1'b1;
            state_q <= ST_FINISH;
          end
        end
        ST_RDATA: if (mg_ack) begin
          rbuf_q[win_q*MG_DATA_W +: MG_DATA_W] <= mg_rdata;
          if (win_q == '0) state_q <= ST_FINISH;
          else             win_q   <= win_q - WIN_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mg_req    = 1'b0;
    mg_write  = 1'b0;
    mg_regnum = REG_COMMAND;
    mg_wdata  = '0;
    case (state_q)
      ST_PAGE: begin
        mg_req    = 1'b1;
        mg_write  = 1'b1;
        mg_regnum = REG_PAGE_SEL;
        mg_wdata  = {page_q, {(MG_DATA_W-PAGE_W-1){1'b0}}, 1'b1};
      end
      ST_WDATA: begin
        mg_req    = 1'b1;
        mg_write  = 1'b1;
        mg_regnum = REG_WINDOW0 + MG_REG_W'(win_q);
        mg_wdata  = wbuf_q[win_q*MG_DATA_W +: MG_DATA_W];
      end
      ST_CMD: begin
        mg_req    = 1'b1;
        mg_write  = 1'b1;
        mg_regnum = REG_COMMAND;
        mg_wdata  = {reg_q, {(MG_DATA_W-REG_W-2){1'b0}}, is_wr_q ? OPC_WRITE : OPC_READ};
      end
      ST_POLL: begin
        mg_req    = 1'b1;
        mg_regnum = REG_COMMAND;
      end
      ST_RDATA: begin
        mg_req    = 1'b1;
        mg_regnum = REG_WINDOW0 + MG_REG_W'(win_q);
      end
      default: ;
    endcase
  end

  assign mg_phy = PHY_ADDR;
  assign done   = (state_q == ST_FINISH);
  assign err    = done && err_q;
  assign rdata  = rbuf_q & mask_q;
endmodule

// File: rtl/mdio_page_bridge_chk.sv
module mdio_page_bridge_chk #(
  parameter int               LEN_W     = 4,
  parameter int               PHY_W     = 5,
  parameter logic [PHY_W-1:0] PHY_ADDR  = 5'h1E,
  parameter int               MG_DATA_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [LEN_W-1:0]     req_len,
  input logic                 done,
  input logic                 err,
  input logic                 mg_req,
  input logic                 mg_write,
  input logic [PHY_W-1:0]     mg_phy,
  input logic [4:0]           mg_regnum,
  input logic [MG_DATA_W-1:0] mg_wdata,
  input logic                 mg_ack
);
  logic bad_len;
  assign bad_len = !(req_len == 4'd1 || req_len == 4'd2 || req_len == 4'd4 ||
                     req_len == 4'd6 || req_len == 4'd8);

  p_phy_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mg_req |-> mg_phy == PHY_ADDR);

  p_hold_until_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mg_req && !mg_ack) |=> (mg_req && $stable(mg_write) && $stable(mg_regnum) && $stable(mg_wdata)));

  p_quiet_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mg_req);

  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  p_bad_len_no_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && bad_len) |=> (done && err && !mg_req));
endmodule

bind mdio_page_bridge mdio_page_bridge_chk #(
  .LEN_W(LEN_W), .PHY_W(PHY_W), .PHY_ADDR(PHY_ADDR), .MG_DATA_W(MG_DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_len(req_len), .done(done), .err(err), .mg_req(mg_req),
  .mg_write(mg_write), .mg_phy(mg_phy), .mg_regnum(mg_regnum),
  .mg_wdata(mg_wdata), .mg_ack(mg_ack)
);

// File: tb/mdio_page_bridge_test.sv
module mdio_page_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [7:0]  req_page = '0, req_reg = '0;
  logic [3:0]  req_len = '0;
  logic [63:0] req_wdata = '0;
  logic        done, err;
  logic [63:0] rdata;
  logic        mg_req, mg_write;
  logic [4:0]  mg_phy, mg_regnum;
  logic [15:0] mg_wdata;
  logic        mg_ack = 1'b0;
  logic [15:0] mg_rdata = '0;

  always #2.5 clk = ~clk;

  mdio_page_bridge uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_page(req_page), .req_reg(req_reg),
    .req_len(req_len), .req_wdata(req_wdata), .done(done), .err(err),
    .rdata(rdata), .mg_req(mg_req), .mg_write(mg_write), .mg_phy(mg_phy),
    .mg_regnum(mg_regnum), .mg_wdata(mg_wdata), .mg_ack(mg_ack),
    .mg_rdata(mg_rdata)
  );

  int checks = 0, fails = 0;

  // management responder log
  logic [4:0]  log_reg [0:255];
  logic        log_wr  [0:255];
  logic [15:0] log_dat [0:255];
  logic [4:0]  log_phy [0:255];
  int          log_n = 0;
  int          busy_left = 0, busy_cfg = 0;

  // expected log
  logic [4:0]  exp_reg [0:255];
  logic        exp_wr  [0:255];
  logic [15:0] exp_dat [0:255];
  int          exp_n = 0;
  logic        exp_err;
  logic [63:0] exp_rd;
  logic        pg_valid = 1'b0;
  logic [7:0]  pg_last = '0;

  localparam logic [63:0] WIN_ALL = 64'h0718_E5F6_C3D4_A1B2;

  function automatic logic [15:0] win_val(input logic [4:0] r);
    return WIN_ALL[16*(r - 5'h18) +: 16];
  endfunction

  initial forever begin
    @(negedge clk);
    if (!rst_n) mg_ack = 1'b0;
    else if (mg_ack) mg_ack = 1'b0;
    else if (mg_req) begin
      if (log_n < 256) begin
        log_reg[log_n] = mg_regnum;
        log_wr[log_n]  = mg_write;
        log_dat[log_n] = mg_write ? mg_wdata : 16'h0;
        log_phy[log_n] = mg_phy;
      end
      log_n++;
      mg_rdata = 16'h0;
      if (mg_write && mg_regnum == 5'h11) busy_left = busy_cfg;
      if (!mg_write && mg_regnum == 5'h11) begin
        if (busy_left > 0) begin
          mg_rdata = 16'h0002;
          busy_left--;
        end
      end else if (!mg_write && mg_regnum >= 5'h18 && mg_regnum <= 5'h1B)
        mg_rdata = win_val(mg_regnum);
      mg_ack = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic push(input logic [4:0] r, input logic w, input logic [15:0] d);
    exp_reg[exp_n] = r;
    exp_wr[exp_n]  = w;
    exp_dat[exp_n] = d;
    exp_n++;
  endtask

  task automatic build_exp(input logic wr, input logic [7:0] pg, input logic [7:0] rg,
                           input logic [3:0] ln, input logic [63:0] d, input int busy);
    logic [63:0] m;
    int top, polls;
    exp_n = 0; exp_rd = '0; exp_err = 1'b0;
    if (!(ln == 1 || ln == 2 || ln == 4 || ln == 6 || ln == 8)) begin
      exp_err = 1'b1;
      return;
    end
    if (!pg_valid || pg_last != pg) begin
      push(5'h10, 1'b1, {pg, 8'h01});
      pg_valid = 1'b1;
      pg_last  = pg;
    end
    m = '0;
    for (int b = 0; b < 8; b++) if (b < ln) m[8*b +: 8] = 8'hFF;
    top = (ln == 8) ? 3 : (ln == 6) ? 2 : (ln == 4) ? 1 : 0;
    if (wr) for (int w = top; w >= 0; w--) push(5'(5'h18 + w), 1'b1, (d & m) >> (16*w));
    push(5'h11, 1'b1, {rg, 6'b0, wr ? 2'b01 : 2'b10});
    polls = (busy < 100) ? busy + 1 : 100;
    exp_err = (busy >= 100);
    for (int p = 0; p < polls; p++) push(5'h11, 1'b0, 16'h0);
    if (!wr && !exp_err) begin
      for (int w = top; w >= 0; w--) push(5'(5'h18 + w), 1'b0, 16'h0);
      exp_rd = WIN_ALL & m;
    end
  endtask

  task automatic run_req(input logic wr, input logic [7:0] pg, input logic [7:0] rg,
                         input logic [3:0] ln, input logic [63:0] d, input int busy,
                         input string tag);
    int wait_c;
    bit seq_ok;
    int bad;
    build_exp(wr, pg, rg, ln, d, busy);
    busy_cfg = busy;
    log_n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_page = pg; req_reg = rg;
    req_len = ln; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, {tag, " R9 ready low after accept"}, 64'(req_ready), 0);
    wait_c = 0;
    while (!done && wait_c < 3000) begin
      @(negedge clk);
      wait_c++;
    end
    check(done == 1'b1, {tag, " R9 done seen"}, 64'(done), 1);
    check(err == exp_err, {tag, " R5/R7 err flag"}, 64'(err), 64'(exp_err));
    if (!wr) check(rdata == exp_rd, {tag, " R6 read value"}, rdata, exp_rd);
    seq_ok = (log_n == exp_n);
    bad = -1;
    if (seq_ok)
      for (int i = 0; i < exp_n; i++)
        if (bad < 0 && (log_reg[i] != exp_reg[i] || log_wr[i] != exp_wr[i] ||
                        log_dat[i] != exp_dat[i] || log_phy[i] != 5'h1E)) bad = i;
    if (!seq_ok)
      check(1'b0, {tag, " R2/R3/R4/R5/R6/R7 access count"}, 64'(log_n), 64'(exp_n));
    else if (bad >= 0)
      check(1'b0, {tag, " R1/R2/R3/R4/R6 access content"},
            {log_phy[bad], log_wr[bad], log_reg[bad], log_dat[bad]},
            {5'h1E, exp_wr[bad], exp_reg[bad], exp_dat[bad]});
    else check(1'b1, {tag, " R1 R2 R3 R4 access sequence"}, 0, 0);
    @(negedge clk);
    check(done == 1'b0 && req_ready == 1'b1 && mg_req == 1'b0,
          {tag, " R9 R8 single done, back to idle"}, {done, req_ready, mg_req}, 3'b010);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pg_valid = 1'b0;
  endtask

  localparam int NV = 9;
  localparam logic [84:0] VEC [0:NV-1] = '{
    {1'b1, 8'h34, 8'h00, 4'd1, 64'h0000_0000_0000_FFA5},
    {1'b1, 8'h34, 8'h10, 4'd2, 64'h0000_0000_0000_1234},
    {1'b0, 8'h02, 8'h30, 4'd2, 64'h0},
    {1'b1, 8'h05, 8'h10, 4'd8, 64'h1122_3344_5566_7788},
    {1'b0, 8'h05, 8'h10, 4'd6, 64'h0},
    {1'b0, 8'h05, 8'h08, 4'd4, 64'h0},
    {1'b1, 8'h00, 8'h79, 4'd4, 64'h0000_0000_DEAD_BEEF},
    {1'b0, 8'h00, 8'h0E, 4'd1, 64'h0},
    {1'b0, 8'h00, 8'h20, 4'd8, 64'h0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R9 R8: reset state
    check(req_ready == 1'b1 && done == 1'b0 && err == 1'b0 && mg_req == 1'b0,
          "R9 R8 reset state", {req_ready, done, err, mg_req}, 4'b1000);

    for (int i = 0; i < NV; i++)
      run_req(VEC[i][84], VEC[i][83:76], VEC[i][75:68], VEC[i][67:64], VEC[i][63:0],
              i % 3, $sformatf("vec%0d", i));

    // R5: boundary one short of the limit succeeds, limit reached times out
    run_req(1'b1, 8'h00, 8'h40, 4'd2, 64'h00AA, 99, "R5 busy99");
    run_req(1'b1, 8'h00, 8'h41, 4'd2, 64'h00BB, 150, "R5 timeout");
    run_req(1'b0, 8'h00, 8'h42, 4'd4, 64'h0, 150, "R5 read timeout");

    // R7: invalid lengths, no access
    run_req(1'b1, 8'h07, 8'h00, 4'd3, 64'h1, 0, "R7 len3");
    run_req(1'b0, 8'h07, 8'h00, 4'd0, 64'h0, 0, "R7 len0");
    run_req(1'b0, 8'h07, 8'h00, 4'd9, 64'h0, 0, "R7 len9");

    // R2: page cache cleared by reset
    run_req(1'b0, 8'h11, 8'h02, 4'd2, 64'h0, 0, "R2 before reset");
    do_reset();
    run_req(1'b0, 8'h11, 8'h02, 4'd2, 64'h0, 0, "R2 after reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule